// File: doc/BRIEF.md
# Stack-relative register operation unit

This block executes one two-operand instruction per clock against a 64-entry register space, part of which acts as a register-resident stack. A 2-bit stack selector picks the first operand: the constant zero, the constant one, the value on top of the stack, or that same top value taken with a pop. A full 6-bit address picks the second operand from anywhere in the register space. A 3-bit operation field chooses the ALU function.

The selector does more than pick an operand. It also fixes the slot that receives the result and how the stack pointer moves. The two constant selectors push: the result goes one slot above the top and the pointer advances. The top-of-stack selector updates the top in place. The popping selector writes one slot below and the pointer retreats.

This lets one instruction encoding cover three uses: pushing a copy of any register (OR with zero), combining into the top in place, and pop-and-combine. The stack lives in a configurable, power-of-two sized window of the register space, and the pointer wraps inside that window.

Top module: `sro_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `sp_out` equals STACK_BASE (32 by default) and `done` is low.
- R2: Selector code 0 gives first operand 0, code 1 gives 1, and codes 2 and 3 both give the register at the current stack pointer.
- R3: The second operand is the register named by the 6-bit address, read as it stood before this instruction's write, even when that address is the current top or the destination slot.
- R4: Operation code 0 adds, 1 subtracts (first minus second), 2 is AND, 3 is OR, 4 is XOR, and codes 5 to 7 produce zero.
- R5: With selector 0 or 1 the result is written one slot above the pointer and the pointer moves to that slot.
- R6: With selector 2 the result is written at the pointer and the pointer does not change.
- R7: With selector 3 the result is written one slot below the pointer and the pointer moves to that slot.
- R8: The pointer always stays within [STACK_BASE, STACK_BASE+STACK_DEPTH-1]: stepping up from the highest slot gives the lowest slot, and stepping down from the lowest gives the highest.
- R9: Each accepted instruction completes on one clock edge. In the following cycle `done` is high for that cycle only, `wb_addr` and `wb_data` show the slot written and the value written, and `wb_addr` equals the new `sp_out`.
- R10: A cycle without `in_valid` writes no register, leaves `sp_out` unchanged and leaves `done` low.
- R11: At configuration, register i holds i * 32'h01010101. Reset does not clear the register space.
- R12: Selector 0 with OR pushes an exact copy of the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_sel | input | 2 | Stack selector (0 zero, 1 one, 2 top, 3 top with pop) |
| in_raddr | input | 6 | Second operand register address |
| in_op | input | 3 | ALU operation code |
| sp_out | output | 6 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |
| wb_addr | output | 6 | Register written by the completed instruction |
| wb_data | output | 32 | Value written by the completed instruction |

## Verification
Several checks hold on every cycle. The assertions check the pointer movement for each selector class, including wrap inside the window. They also check that the pointer never leaves the stack window, that `done` follows exactly the accepted instructions, that the write-back address always equals the new pointer, and that idle cycles are quiet.

The data results cannot be checked that way. Whether the right operands were read (especially the pre-update value when the address names the top or the destination slot) and whether the ALU result is right can only be shown by the bench's scenarios. The bench runs a reference model of the full register space over directed corner cases and a long random instruction stream.

// File: rtl/sro_pkg.sv
package sro_pkg;
  localparam logic [1:0] SEL_ZERO = 2'd0;
  localparam logic [1:0] SEL_ONE  = 2'd1;
  localparam logic [1:0] SEL_TOP  = 2'd2;
  localparam logic [1:0] SEL_POP  = 2'd3;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  typedef enum logic [1:0] {
    MOVE_UP,
    MOVE_HOLD,
    MOVE_DOWN
  } sp_move_e;

  function automatic sp_move_e move_of(logic [1:0] sel);
    case (sel)
      SEL_ZERO, SEL_ONE: return MOVE_UP;
      SEL_TOP:           return MOVE_HOLD;
      default:           return MOVE_DOWN;
    endcase
  endfunction
endpackage

// File: rtl/sro_stack_ptr.sv
module sro_stack_ptr #(
  parameter int ADDR_W      = 6,
  parameter int STACK_BASE  = 32,
  parameter int STACK_DEPTH = 32
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic [1:0]        sel,
  output logic [ADDR_W-1:0] dest
);
  import sro_pkg::*;

  localparam int OFF_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(STACK_BASE);

  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] off_n;
  sp_move_e         mv;

  always_comb begin
    mv  = move_of(sel);
    off = OFF_W'(sp - BASE_A);
    case (mv)
      MOVE_UP:   off_n = off + OFF_W'(1);
      MOVE_DOWN: off_n = off - OFF_W'(1);
      default:   off_n = off;
    endcase
    dest = BASE_A + ADDR_W'(off_n);
  end
endmodule

// File: rtl/sro_alu.sv
module sro_alu #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  import sro_pkg::*;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/sro_regfile.sv
module sro_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(32'(i) * 32'h0101_0101);
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sro_unit.sv
module sro_unit #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int STACK_BASE  = 32,
  parameter int STACK_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_sel,
  input  logic [ADDR_W-1:0] in_raddr,
  input  logic [2:0]        in_op,
  output logic [ADDR_W-1:0] sp_out,
  output logic              done,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  import sro_pkg::*;

  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] dest;
  logic [DATA_W-1:0] top_val;
  logic [DATA_W-1:0] any_val;
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] result;
  logic              wr_en;
  logic              done_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;

  assign wr_en = in_valid & ~rst;

  sro_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rf_i (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (dest),
    .wdata   (result),
    .raddr_a (sp_q),
    .rdata_a (top_val),
    .raddr_b (in_raddr),
    .rdata_b (any_val)
  );

  sro_stack_ptr #(
    .ADDR_W(ADDR_W), .STACK_BASE(STACK_BASE), .STACK_DEPTH(STACK_DEPTH)
  ) sp_i (
    .sp   (sp_q),
    .sel  (in_sel),
    .dest (dest)
  );

  always_comb begin
    case (in_sel)
      SEL_ZERO: opnd_a = '0;
      SEL_ONE:  opnd_a = DATA_W'(1);
      default:  opnd_a = top_val;
    endcase
  end

  sro_alu #(.DATA_W(DATA_W)) alu_i (
    .op (in_op),
    .a  (opnd_a),
    .b  (any_val),
    .y  (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= ADDR_W'(STACK_BASE);
      done_q    <= 1'b0;
      wb_addr_q <= ADDR_W'(STACK_BASE);
      wb_data_q <= '0;
    end else begin
      done_q <= in_valid;
      if (in_valid) begin
        sp_q      <= dest;
        wb_addr_q <= dest;
        wb_data_q <= result;
      end
    end
  end

  assign sp_out  = sp_q;
  assign done    = done_q;
  assign wb_addr = wb_addr_q;
  assign wb_data = wb_data_q;
endmodule

// File: rtl/sro_unit_chk.sv
module sro_unit_chk #(
  parameter int ADDR_W      = 6,
  parameter int STACK_BASE  = 32,
  parameter int STACK_DEPTH = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        in_sel,
  input logic [ADDR_W-1:0] sp_out,
  input logic              done,
  input logic [ADDR_W-1:0] wb_addr
);
  localparam int OFF_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  function automatic logic [ADDR_W-1:0] step(logic [ADDR_W-1:0] p, logic [ADDR_W-1:0] d);
    logic [OFF_W-1:0] o;
    o = OFF_W'(p - ADDR_W'(STACK_BASE) + d);
    return ADDR_W'(STACK_BASE) + ADDR_W'(o);
  endfunction

  a_r5_push_up: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_sel[1] |=> sp_out == step($past(sp_out), ADDR_W'(1)));

  a_r6_top_hold: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sel == 2'd2 |=> sp_out == $past(sp_out));

  a_r7_pop_down: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sel == 2'd3 |=> sp_out == step($past(sp_out), {ADDR_W{1'b1}}));

  a_r8_in_window: assert property (@(posedge clk) disable iff (rst)
    int'(sp_out) >= STACK_BASE && int'(sp_out) < STACK_BASE + STACK_DEPTH);

  a_r9_done_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);

  a_r9_wb_at_sp: assert property (@(posedge clk) disable iff (rst)
    done |-> wb_addr == sp_out);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !done && $stable(sp_out));
endmodule

bind sro_unit sro_unit_chk #(
  .ADDR_W(ADDR_W), .STACK_BASE(STACK_BASE), .STACK_DEPTH(STACK_DEPTH)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_sel   (in_sel),
  .sp_out   (sp_out),
  .done     (done),
  .wb_addr  (wb_addr)
);

// File: tb/sro_unit_tb_top.sv
module sro_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE  = 32;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_sel = '0;
  logic [5:0]  in_raddr = '0;
  logic [2:0]  in_op = '0;
  logic [5:0]  sp_out;
  logic        done;
  logic [5:0]  wb_addr;
  logic [31:0] wb_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model [64];
  int msp;

  always #(CLK_PERIOD/2) clk = ~clk;

  sro_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
    .in_raddr(in_raddr), .in_op(in_op), .sp_out(sp_out), .done(done),
    .wb_addr(wb_addr), .wb_data(wb_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wrap(input int p, input int d);
    return BASE + (((p - BASE + d) % DEPTH) + DEPTH) % DEPTH;
  endfunction

  function automatic logic [31:0] alu(input logic [2:0] op, input logic [31:0] a,
                                      input logic [31:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  // Drives at a falling edge, checks at the next falling edge; leaves in_valid high.
  task automatic run(input logic [1:0] sel, input logic [5:0] ra, input logic [2:0] op);
    logic [31:0] a, b, r;
    int dst;
    string rq;
    a = (sel == 2'd0) ? 32'd0 : (sel == 2'd1) ? 32'd1 : model[msp];
    b = model[ra];
    r = alu(op, a, b);
    dst = (sel[1] == 1'b0) ? wrap(msp, 1) : (sel == 2'd2) ? msp : wrap(msp, -1);
    rq = (sel[1] == 1'b0) ? "R5" : (sel == 2'd2) ? "R6" : "R7";
    in_valid = 1'b1; in_sel = sel; in_raddr = ra; in_op = op;
    model[dst] = r;
    msp = dst;
    @(posedge clk);
    @(negedge clk);
    check(done === 1'b1, "R9 done", 32'(done), 32'd1);
    check(wb_addr === 6'(dst), rq, 32'(wb_addr), 32'(dst));
    check(sp_out === 6'(dst), "R8 sp", 32'(sp_out), 32'(dst));
    check(wb_data === r, "R4 R2 R3 data", wb_data, r);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(done === 1'b0, "R10 done", 32'(done), 32'd0);
      check(sp_out === 6'(msp), "R10 sp", 32'(sp_out), 32'(msp));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 32'(i) * 32'h0101_0101;
    msp = BASE;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sp_out === 6'(BASE), "R1 sp", 32'(sp_out), 32'(BASE));
    check(done === 1'b0, "R1 done", 32'(done), 32'd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(sp_out === 6'(BASE), "R1 sp after", 32'(sp_out), 32'(BASE));
    check(done === 1'b0, "R1 done after", 32'(done), 32'd0);

    // R12 / R11: push copy of register 5 (initial content)
    run(2'd0, 6'd5, 3'd3);
    check(wb_data === 32'h0505_0505, "R12 copy", wb_data, 32'h0505_0505);
    run(2'd1, 6'd2, 3'd0);                 // R2 const one
    run(2'd2, 6'(msp), 3'd4);              // R3 address equals top, R6
    check(wb_data === 32'd0, "R3 top self xor", wb_data, 32'd0);
    run(2'd0, 6'(wrap(msp, 1)), 3'd0);     // R3 address equals destination slot
    check(wb_data === 32'(35) * 32'h0101_0101, "R3 pre-update", wb_data,
          32'(35) * 32'h0101_0101);
    run(2'd3, 6'd3, 3'd1);                 // R7 pop with subtract
    run(2'd2, 6'd9, 3'd5);                 // R4 undefined codes
    run(2'd2, 6'd9, 3'd6);
    run(2'd1, 6'd9, 3'd7);
    run(2'd2, 6'd7, 3'd2);
    idle(3);                               // R10

    // R8 wrap upward then downward
    while (msp != BASE + DEPTH - 1) run(2'd0, 6'(msp % 32), 3'd3);
    run(2'd1, 6'd1, 3'd0);
    check(sp_out === 6'(BASE), "R8 wrap up", 32'(sp_out), 32'(BASE));
    run(2'd3, 6'd0, 3'd3);
    check(sp_out === 6'(BASE + DEPTH - 1), "R8 wrap down", 32'(sp_out),
          32'(BASE + DEPTH - 1));
    idle(1);

    for (int k = 0; k < 500; k++) begin
      if ($urandom_range(0, 7) == 0) idle(1);
      run(2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)),
          3'($urandom_range(0, 7)));
    end
    idle(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule